// File: doc/BRIEF.md
# Capture/Compare Timer Channel

A single timer channel built around a 16-bit free-running up counter and four general registers (slots A, B, C and D). Each slot works either as an output-compare register, raising its flag when the running counter equals it, or as an input-capture register that snapshots the counter when its capture pin shows the selected edge. Slots C and D can also be turned into holding registers for A and B. In compare mode the held value is loaded into the partner on its match, so the next compare point can be prepared without a race. In capture mode the previous partner value is kept on each new capture, so two successive timestamps are available.

Every slot has a status flag. Software clears a flag by reading the status register and seeing the bit as 1, then writing a 0 to that bit. Flag A also drives a request line to a transfer engine. The engine's acknowledge clears flag A unless its keep-flag input is high. All registers sit on a simple 16-bit bus that takes only full-width accesses.

Top module: `cct_channel`

## Requirements
- R1: After reset the counter reads 0x0000, every general register reads 0xFFFF, and all flags, `cmp_match` bits and `xfer_req` are 0.
- R2: While the run bit (control bit 0) is 1, the counter adds one on each clock and wraps from 0xFFFF to 0x0000. A full-width bus write to the counter (address 2) loads the written value and takes the place of that cycle's increment.
- R3: A slot in compare mode (its mode bit, control bit 1+slot, is 0) drives its `cmp_match` bit high in every cycle where run is 1 and the counter equals the slot. Its flag (status bit = slot index, address 1) is 1 from the next clock edge.
- R4: A slot in capture mode (mode bit 1) passes its `cap_in` bit through two synchronising flops and watches for a rising edge, or for a falling edge when its polarity bit (control bit 7+slot) is 1. On that edge the slot loads the counter value and its flag sets, three clock edges after the pin changes. The opposite edge does nothing.
- R5: A status write with a 0 in a flag's bit clears that flag only if a full-width status read has returned the flag as 1 since it last set. A 0 written without such a read has no effect, and writing 1 never changes a flag.
- R6: If a flag's set event and a valid clear fall in the same cycle, the flag stays 1, and a fresh status read is needed before a 0 write can clear it.
- R7: `xfer_req` equals flag A. A cycle with `xfer_ack` high and `xfer_keep` low clears flag A. With `xfer_keep` high, the acknowledge leaves the flag unchanged.
- R8: A bus write whose byte enables are not both 1 changes no register.
- R9: With control bit 5 set, slot C holds the next value for A. When A in compare mode matches, A loads C's value and flag A sets.
- R10: With control bit 6 set, slot D holds history for B. When B in capture mode captures, B loads the counter and D loads B's previous value.
- R11: A slot used as a holding register never sets its own flag and ignores its own capture pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address: 0 control, 1 status, 2 counter, 4..7 slots A..D |
| bus_be | input | 2 | Byte enables; an access counts only when both are 1 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| cap_in | input | 4 | Capture pins for slots A..D (asynchronous) |
| cmp_match | output | 4 | Per-slot compare match in the current cycle |
| flag_o | output | 4 | Per-slot status flags |
| xfer_req | output | 1 | Transfer request, follows flag A |
| xfer_ack | input | 1 | Transfer acknowledge |
| xfer_keep | input | 1 | When 1, the acknowledge leaves flag A unchanged |

## Verification
A compare match that sets a flag and a software 0-write that would clear it can land in the same clock. The bench arms flag A with a status read, then sets the counter and slot A so that the match falls exactly on the edge of a status write of zero, and expects the flag to survive. It then expects a second zero write without a new read to be ignored as well. Timing is fixed by stopping the counter, preloading it, and counting edges from the run-bit write.

// File: rtl/cct_pkg.sv
package cct_pkg;

    localparam int NUM_SLOTS = 4;
    localparam int ADDR_W    = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_SLOT = 3'd4;

    // Control word, bit 0 first: run, capture mode per slot, holding enables, falling edge per slot
    typedef struct packed {
        logic [NUM_SLOTS-1:0]   fall;
        logic [NUM_SLOTS/2-1:0] hold_en;
        logic [NUM_SLOTS-1:0]   cap_mode;
        logic                   run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Slot paired with a given slot (A<->C, B<->D)
    function automatic int slot_partner(input int idx);
        return idx ^ (NUM_SLOTS / 2);
    endfunction

    function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
        return ADDR_SLOT + ADDR_W'(idx);
    endfunction

endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (run)
            count <= count + W'(1);
    end

endmodule

// File: rtl/cct_edge_detect.sv
module cct_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic fall_sel,
    output logic evt
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              cur;

    assign cur = sync_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= cur;
        end
    end

    assign evt = fall_sel ? (prev_q & ~cur) : (cur & ~prev_q);

endmodule

// File: rtl/cct_flag.sv
module cct_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    input  logic ext_clr_i,
    output logic flag_o
);

    logic seen_q;
    logic sw_clr;
    logic clr;

    assign sw_clr = flag_o && seen_q && wr_i && !wr_bit_i;
    assign clr    = sw_clr || (flag_o && ext_clr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
            seen_q <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
            seen_q <= 1'b0;
        end else if (clr) begin
            flag_o <= 1'b0;
            seen_q <= 1'b0;
        end else if (rd_i && flag_o) begin
            seen_q <= 1'b1;
        end
    end

endmodule

// File: rtl/cct_channel.sv
module cct_channel
    import cct_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_sel,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [CNT_W/8-1:0]     bus_be,
    input  logic [CNT_W-1:0]       bus_wdata,
    output logic [CNT_W-1:0]       bus_rdata,
    input  logic [NUM_SLOTS-1:0]   cap_in,
    output logic [NUM_SLOTS-1:0]   cmp_match,
    output logic [NUM_SLOTS-1:0]   flag_o,
    output logic                   xfer_req,
    input  logic                   xfer_ack,
    input  logic                   xfer_keep
);

    localparam int HALF = NUM_SLOTS / 2;

    ctrl_t                ctrl_q;
    logic [CNT_W-1:0]     count_q;
    logic [CNT_W-1:0]     gr_q [NUM_SLOTS];
    logic [CNT_W-1:0]     gr_d [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] cap_edge;
    logic [NUM_SLOTS-1:0] cap_evt;
    logic [NUM_SLOTS-1:0] is_hold;
    logic [NUM_SLOTS-1:0] has_hold;
    logic [NUM_SLOTS-1:0] set_evt;
    logic [NUM_SLOTS-1:0] ext_clr;
    logic [NUM_SLOTS-1:0] flag_q;
    logic                 full_acc;
    logic                 wr_hit;
    logic                 rd_hit;
    logic                 cnt_wr;
    logic                 stat_rd;
    logic                 stat_wr;

    // Bus decode: only full-width accesses have any effect
    assign full_acc = bus_sel && (bus_be == '1);
    assign wr_hit   = full_acc && bus_we;
    assign rd_hit   = full_acc && !bus_we;
    assign cnt_wr   = wr_hit && (bus_addr == ADDR_CNT);
    assign stat_rd  = rd_hit && (bus_addr == ADDR_STAT);
    assign stat_wr  = wr_hit && (bus_addr == ADDR_STAT);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_hit && (bus_addr == ADDR_CTRL))
            ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    cct_counter #(.W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q.run),
        .load     (cnt_wr),
        .load_val (bus_wdata),
        .count    (count_q)
    );

    generate
        for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
            cct_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
                .clk      (clk),
                .rst      (rst),
                .din      (cap_in[gi]),
                .fall_sel (ctrl_q.fall[gi]),
                .evt      (cap_edge[gi])
            );

            cct_flag u_flag (
                .clk       (clk),
                .rst       (rst),
                .set_i     (set_evt[gi]),
                .rd_i      (stat_rd),
                .wr_i      (stat_wr),
                .wr_bit_i  (bus_wdata[gi]),
                .ext_clr_i (ext_clr[gi]),
                .flag_o    (flag_q[gi])
            );
        end
    endgenerate

    // Per-slot role and event decode
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            is_hold[i]   = (i >= HALF) && ctrl_q.hold_en[i % HALF];
            has_hold[i]  = (i < HALF)  && ctrl_q.hold_en[i % HALF];
            cap_evt[i]   = !is_hold[i] && ctrl_q.cap_mode[i] && cap_edge[i];
            cmp_match[i] = !is_hold[i] && !ctrl_q.cap_mode[i] && ctrl_q.run
                           && (count_q == gr_q[i]);
            set_evt[i]   = cap_evt[i] || cmp_match[i];
        end
    end

    always_comb begin
        ext_clr    = '0;
        ext_clr[0] = xfer_ack && !xfer_keep;
    end

    // Slot next-state: hardware events outrank bus writes
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            gr_d[i] = gr_q[i];
            if (wr_hit && (bus_addr == slot_addr(i)))
                gr_d[i] = bus_wdata;
            if (has_hold[i] && cmp_match[i])
                gr_d[i] = gr_q[slot_partner(i)];
            if (cap_evt[i])
                gr_d[i] = count_q;
            if (is_hold[i] && cap_evt[slot_partner(i)])
                gr_d[i] = gr_q[slot_partner(i)];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rst)
                gr_q[i] <= '1;
            else
                gr_q[i] <= gr_d[i];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: bus_rdata = CNT_W'(ctrl_q);
            ADDR_STAT: bus_rdata = CNT_W'(flag_q);
            ADDR_CNT:  bus_rdata = count_q;
            default: begin
                for (int i = 0; i < NUM_SLOTS; i++)
                    if (bus_addr == slot_addr(i))
                        bus_rdata = gr_q[i];
            end
        endcase
    end

    assign flag_o   = flag_q;
    assign xfer_req = flag_q[0];

endmodule

// File: rtl/cct_channel_chk.sv
module cct_channel_chk
    import cct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 run,
    input logic                 cnt_wr,
    input logic [CNT_W-1:0]     count,
    input logic [NUM_SLOTS-1:0] cmp_match,
    input logic [NUM_SLOTS-1:0] set_evt,
    input logic [NUM_SLOTS-1:0] flags,
    input logic                 xfer_ack,
    input logic                 xfer_keep,
    input logic                 hold_a,
    input logic [CNT_W-1:0]     gr_a,
    input logic [CNT_W-1:0]     gr_c,
    input logic                 bus_sel,
    input logic                 bus_we,
    input logic [CNT_W/8-1:0]   bus_be,
    input logic [ADDR_W-1:0]    bus_addr
);

    logic stat_write;
    assign stat_write = bus_sel && bus_we && (bus_addr == ADDR_STAT);

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        run && !cnt_wr |=> count == $past(count) + CNT_W'(1));

    p_count_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        run && !cnt_wr && (count == '1) |=> count == '0);

    p_partial_write_r8: assert property (@(posedge clk) disable iff (rst)
        bus_sel && bus_we && (bus_be != '1) && (bus_addr == ADDR_CNT) && !run
        |=> $stable(count));

    p_ack_clear_r7: assert property (@(posedge clk) disable iff (rst)
        xfer_ack && !xfer_keep && !set_evt[0] |=> !flags[0]);

    p_hold_load_r9: assert property (@(posedge clk) disable iff (rst)
        hold_a && cmp_match[0] |=> gr_a == $past(gr_c));

    generate
        for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_chk
            p_match_flag_r3: assert property (@(posedge clk) disable iff (rst)
                cmp_match[gi] |=> flags[gi]);

            p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
                set_evt[gi] |=> flags[gi]);

            p_flag_holds_r5: assert property (@(posedge clk) disable iff (rst)
                flags[gi] && !stat_write && !(gi == 0 && xfer_ack) |=> flags[gi]);
        end
    endgenerate

endmodule

bind cct_channel cct_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (ctrl_q.run),
    .cnt_wr    (cnt_wr),
    .count     (count_q),
    .cmp_match (cmp_match),
    .set_evt   (set_evt),
    .flags     (flag_q),
    .xfer_ack  (xfer_ack),
    .xfer_keep (xfer_keep),
    .hold_a    (ctrl_q.hold_en[0]),
    .gr_a      (gr_q[0]),
    .gr_c      (gr_q[2]),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_be    (bus_be),
    .bus_addr  (bus_addr)
);

// File: tb/test_cct_channel.sv
module test_cct_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [1:0]  bus_be = 2'b11;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [3:0]  cap_in = 4'h0;
    logic [3:0]  cmp_match;
    logic [3:0]  flag_o;
    logic        xfer_req;
    logic        xfer_ack = 1'b0;
    logic        xfer_keep = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cct_channel i_cct_channel (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_in    (cap_in),
        .cmp_match (cmp_match),
        .flag_o    (flag_o),
        .xfer_req  (xfer_req),
        .xfer_ack  (xfer_ack),
        .xfer_keep (xfer_keep)
    );

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_CNT  = 3'd2;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_be = 2'b11;
    endtask

    task automatic rd(input logic [2:0] a);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = 2'b11;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic clear_all();
        rd(A_STAT);
        wr(A_STAT, 16'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic [15:0] cv;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        peek(A_CNT, v);  chk("R1 counter", v, 16'h0000);
        for (int i = 0; i < 4; i++) begin
            peek(3'(4 + i), v); chk("R1 slot", v, 16'hFFFF);
        end
        chk("R1 flags", {12'h0, flag_o}, 16'h0);
        chk("R1 match", {12'h0, cmp_match}, 16'h0);
        chk("R1 req", {15'h0, xfer_req}, 16'h0);

        // R2 counting and wrap, all slots in capture mode so no match occurs
        wr(A_CTRL, 16'h001E);
        wr(A_CNT, 16'hFFFC);
        wr(A_CTRL, 16'h001F);
        for (int k = 0; k < 8; k++) begin
            peek(A_CNT, v);
            chk("R2 count step", v, 16'(16'hFFFC + k));
            @(negedge clk);
        end
        wr(A_CNT, 16'h1234);
        peek(A_CNT, v); chk("R2 write beats increment", v, 16'h1234);
        wr(A_CTRL, 16'h001E);

        // R8 partial writes ignored
        wr(A_CNT, 16'h0042);
        wr(A_CNT, 16'h9999, 2'b10);
        peek(A_CNT, v); chk("R8 counter partial", v, 16'h0042);
        wr(3'd4, 16'h1111, 2'b01);
        peek(3'd4, v); chk("R8 slot partial", v, 16'hFFFF);
        wr(A_CTRL, 16'h0001, 2'b01);
        peek(A_CTRL, v); chk("R8 control partial", v, 16'h001E);

        // R3 compare sweep over every slot, R5 clear rules on slot A
        for (int i = 0; i < 4; i++) begin
            wr(A_CTRL, 16'h0000);
            wr(A_CNT, 16'h0010);
            wr(3'(4 + i), 16'h0014);
            wr(A_CTRL, 16'h0001);
            repeat (4) @(negedge clk);
            chk("R3 match pulse", {12'h0, cmp_match}, 16'(1 << i));
            chk("R3 flag not yet", {12'h0, flag_o}, 16'h0);
            @(negedge clk);
            chk("R3 flag set", {12'h0, flag_o}, 16'(1 << i));
            wr(A_CTRL, 16'h0000);
            wr(3'(4 + i), 16'hFFFF);
            if (i == 0) begin
                wr(A_STAT, 16'h0);
                chk("R5 zero without read", {15'h0, flag_o[0]}, 16'h1);
                rd(A_STAT);
                wr(A_STAT, 16'h000F);
                chk("R5 write one", {15'h0, flag_o[0]}, 16'h1);
                wr(A_STAT, 16'h0);
                chk("R5 read then zero", {15'h0, flag_o[0]}, 16'h0);
            end else begin
                clear_all();
                chk("R5 cleared", {12'h0, flag_o}, 16'h0);
            end
        end

        // R6 set and clear in the same cycle
        wr(A_CNT, 16'h0022);
        wr(3'd4, 16'h0022);
        wr(A_CTRL, 16'h0001);
        wr(A_CTRL, 16'h0000);
        chk("R6 flag primed", {15'h0, flag_o[0]}, 16'h1);
        rd(A_STAT);
        wr(A_CNT, 16'h0020);
        wr(A_CTRL, 16'h0001);
        repeat (2) @(negedge clk);
        wr(A_STAT, 16'h0);
        chk("R6 set wins", {15'h0, flag_o[0]}, 16'h1);
        wr(A_CTRL, 16'h0000);
        wr(A_STAT, 16'h0);
        chk("R6 needs new read", {15'h0, flag_o[0]}, 16'h1);
        clear_all();
        chk("R6 cleared after read", {15'h0, flag_o[0]}, 16'h0);
        wr(3'd4, 16'hFFFF);

        // R9 holding register for a compare slot
        wr(A_CTRL, 16'h0020);
        wr(A_CNT, 16'h002E);
        wr(3'd4, 16'h0030);
        wr(3'd6, 16'h0050);
        wr(A_CTRL, 16'h0021);
        repeat (3) @(negedge clk);
        peek(3'd4, v); chk("R9 A took C", v, 16'h0050);
        chk("R9 flag A", {15'h0, flag_o[0]}, 16'h1);
        chk("R11 flag C idle", {15'h0, flag_o[2]}, 16'h0);
        wr(A_CTRL, 16'h0000);

        // R7 transfer acknowledge
        chk("R7 request", {15'h0, xfer_req}, 16'h1);
        xfer_ack = 1'b1; xfer_keep = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
        chk("R7 keep", {15'h0, xfer_req}, 16'h1);
        xfer_ack = 1'b1; xfer_keep = 1'b0;
        @(negedge clk);
        xfer_ack = 1'b0;
        chk("R7 ack clears", {15'h0, flag_o[0]}, 16'h0);
        wr(3'd4, 16'hFFFF);
        wr(3'd6, 16'hFFFF);

        // R4 capture sweep, rising then falling polarity
        for (int i = 0; i < 4; i++) begin
            cv = 16'(16'h0100 + i * 16'h0011);
            wr(A_CTRL, 16'h001E);
            wr(A_CNT, cv);
            cap_in[i] = 1'b1;
            repeat (4) @(negedge clk);
            peek(3'(4 + i), v); chk("R4 rising capture", v, cv);
            chk("R4 capture flag", {12'h0, flag_o}, 16'(1 << i));
            wr(A_CNT, 16'h0777);
            cap_in[i] = 1'b0;
            repeat (4) @(negedge clk);
            peek(3'(4 + i), v); chk("R4 falling ignored", v, cv);
            wr(A_CTRL, 16'(16'h001E | (16'h0080 << i)));
            cap_in[i] = 1'b1;
            repeat (4) @(negedge clk);
            peek(3'(4 + i), v); chk("R4 rising ignored", v, cv);
            wr(A_CNT, 16'h0A00 + 16'(i));
            cap_in[i] = 1'b0;
            repeat (4) @(negedge clk);
            peek(3'(4 + i), v); chk("R4 falling capture", v, 16'h0A00 + 16'(i));
            clear_all();
        end

        // R10 holding register for a capture slot, R11 own pin ignored
        wr(A_CTRL, 16'h0054);
        wr(3'd5, 16'hAAAA);
        wr(3'd7, 16'h5555);
        wr(A_CNT, 16'h0300);
        cap_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        peek(3'd5, v); chk("R10 B first", v, 16'h0300);
        peek(3'd7, v); chk("R10 D history", v, 16'hAAAA);
        cap_in[1] = 1'b0;
        wr(A_CNT, 16'h0400);
        repeat (3) @(negedge clk);
        cap_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        peek(3'd5, v); chk("R10 B second", v, 16'h0400);
        peek(3'd7, v); chk("R10 D previous", v, 16'h0300);
        cap_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        peek(3'd7, v); chk("R11 D pin ignored", v, 16'h0300);
        chk("R11 D flag idle", {15'h0, flag_o[3]}, 16'h0);
        chk("R10 B flag", {15'h0, flag_o[1]}, 16'h1);

        finish_run();
    end

endmodule